// File: doc/BRIEF.md
# Three-Phase Adaptive Switching Pulse Controller

This block is the digital core that drives the switch gate of a boost-type high-voltage generator during a ramp. It does not close a feedback loop. It runs open-loop through three stored switching settings as the output voltage climbs past fixed thresholds. Three comparator flags report whether the output is above a low, a middle and a target reference. A start request begins a ramp in the coarse phase, which uses the slowest pulse train. Crossing the low reference moves the controller to the medium setting. Crossing the middle reference moves it to the fine setting, a faster and narrower train that limits overshoot. When the target flag is seen, switching stops completely and the gate is held low.

Each setting is a pair of 5-bit codes, one for the switching period and one for the gate high time, and the two codes are independent. The period is the period code times two clock cycles. The high time is the on code times one clock cycle. This keeps the two-to-one step ratio of the analog oscillator that the block replaces. The three pairs sit in a 30-bit table that is loaded serially. Each new start re-enters the ramp at the phase that matches the comparators at that moment, so a controller can raise the target in steps and restart without first discharging the output.

The FSM has five states. `ST_IDLE` is the state after reset, with no switching. `ST_COARSE`, `ST_MEDIUM` and `ST_FINE` are the three switching phases. `ST_DONE` means the target was reached and the gate is held low. The transitions are:
- start from idle or done goes to the entry phase;
- coarse goes to medium on the low flag;
- coarse or medium goes to fine on the middle flag;
- any switching phase goes to done on the target flag;
- done goes back to the entry phase on start.

The entry phase is done if the target flag is set, else fine if the middle flag is set, else medium if the low flag is set, else coarse.

Top module: `ramp_pulse_ctrl`

## Requirements
- R1: After reset, gate_out is low and stays low until start is seen. The table holds its defaults: coarse period 12 and on 10, medium period 6 and on 4, fine period 3 and on 2.
- R2: A start pulse while idle, with all flags low, enters the coarse phase. gate_out rises in the cycle after the edge that samples start, and the coarse pair sets the pulse train.
- R3: Each period is max(period code,1)×2 clock cycles. The gate is high for the first max(on code,1) cycles of each period. The two codes act independently.
- R4: If the on time is at or above the period, it is clamped to the period minus one cycle, so every period has at least one low cycle. Code 0 is treated as 1.
- R5: Comparator flags pass through a two-flop synchronizer. A flag that is set before an edge changes the phase at the third edge. The low flag selects medium and the middle flag selects fine. Each new phase starts a fresh period with the gate high.
- R6: Once the synchronized target flag is seen during a ramp, the next state is done. gate_out is low in that state and stays low in idle and in done.
- R7: Within a ramp the phase only moves forward. A flag that falls, or a start that arrives during a ramp, has no effect on the pulse train.
- R8: A start while in done re-enters the ramp. The phase is chosen by priority from the synchronized flags: target gives done, middle gives fine, low gives medium, and no flag gives coarse.
- R9: Each cycle with cfg_shift high shifts cfg_data into a 30-bit register, MSB first. A cfg_load pulse copies that register into the table only in idle or done. During switching the pulse is ignored. The field layout is bits 29:25 and 24:20 for the coarse period and on codes, 19:15 and 14:10 for medium, and 9:5 and 4:0 for fine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Ramp start request, sampled each cycle |
| cmp_lo | input | 1 | Comparator: output above the low reference (asynchronous) |
| cmp_mid | input | 1 | Comparator: output above the middle reference (asynchronous) |
| cmp_tgt | input | 1 | Comparator: output above the target reference (asynchronous) |
| cfg_shift | input | 1 | Serial shift enable |
| cfg_data | input | 1 | Serial table data, MSB first |
| cfg_load | input | 1 | Commit the shifted word to the table |
| gate_out | output | 1 | Switch-gate pulse train |

## Verification
The checker asserts several properties on every cycle:
- the gate is low whenever no phase is switching;
- the phase code never steps back during a ramp;
- the last cycle of every period is low, whatever the codes;
- a synchronized target flag always ends the ramp in the next cycle;
- the table does not change while switching.

Other behaviours can only be shown by the bench's scenarios. These are the measured period and high-time lengths for each code pair, the three-edge flag latency, the priority choice of the re-entry phase, and the serial field layout. The bench compares the gate with a cycle model built from the requirements, and it also measures the pulse widths directly for both the directed tables and random tables.

// File: rtl/ramp_pulse_pkg.sv
package ramp_pulse_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COARSE = 3'd1,
        ST_MEDIUM = 3'd2,
        ST_FINE   = 3'd3,
        ST_DONE   = 3'd4
    } phase_e;

    localparam int NUM_SETS = 3;

    function automatic phase_e entry_phase(input logic lo, input logic mid, input logic tgt);
        if (tgt)      return ST_DONE;
        else if (mid) return ST_FINE;
        else if (lo)  return ST_MEDIUM;
        else          return ST_COARSE;
    endfunction

endpackage

// File: rtl/rpc_flag_sync.sv
module rpc_flag_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[s] <= '0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rpc_cfg_table.sv
module rpc_cfg_table #(
    parameter int                      TABLE_W   = 30,
    parameter logic [TABLE_W-1:0]      DEF_TABLE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               sdata,
    input  logic               commit,
    input  logic               commit_ok,
    output logic [TABLE_W-1:0] table_q
);
    logic [TABLE_W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        shreg_q <= '0;
        else if (shift_en) shreg_q <= {shreg_q[TABLE_W-2:0], sdata};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   table_q <= DEF_TABLE;
        else if (commit && commit_ok) table_q <= shreg_q;
    end
endmodule

// File: rtl/rpc_pulse_timer.sv
module rpc_pulse_timer #(
    parameter int CODE_W   = 5,
    parameter int PER_UNIT = 2,
    parameter int ON_UNIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fresh,
    input  logic [CODE_W-1:0] per_code,
    input  logic [CODE_W-1:0] on_code,
    output logic              gate_o,
    output logic              wrap_o
);
    localparam int CNT_W = CODE_W + $clog2(PER_UNIT + ON_UNIT + 1) + 1;

    logic [CNT_W-1:0] cnt_q, cnt_eff, pe_raw, pe, on_raw, te;
    logic [CODE_W-1:0] per_c, on_c;

    always_comb begin
        per_c   = (per_code == '0) ? CODE_W'(1) : per_code;
        on_c    = (on_code  == '0) ? CODE_W'(1) : on_code;
        pe_raw  = CNT_W'(per_c) * CNT_W'(PER_UNIT);
        pe      = (pe_raw < CNT_W'(2)) ? CNT_W'(2) : pe_raw;
        on_raw  = CNT_W'(on_c) * CNT_W'(ON_UNIT);
        te      = (on_raw >= pe) ? (pe - CNT_W'(1)) : on_raw;
        cnt_eff = fresh ? '0 : cnt_q;
        wrap_o  = run && (cnt_eff == (pe - CNT_W'(1)));
        gate_o  = run && (cnt_eff < te);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run)   cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else             cnt_q <= cnt_eff + CNT_W'(1);
    end
endmodule

// File: rtl/ramp_pulse_ctrl.sv
module ramp_pulse_ctrl
    import ramp_pulse_pkg::*;
#(
    parameter int                 CODE_W      = 5,
    parameter int                 PER_UNIT    = 2,
    parameter int                 ON_UNIT     = 1,
    parameter int                 SYNC_STAGES = 2,
    parameter logic [6*CODE_W-1:0] DEF_TABLE  = {5'd12, 5'd10, 5'd6, 5'd4, 5'd3, 5'd2}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmp_lo,
    input  logic cmp_mid,
    input  logic cmp_tgt,
    input  logic cfg_shift,
    input  logic cfg_data,
    input  logic cfg_load,
    output logic gate_out
);
    localparam int PAIR_W  = 2 * CODE_W;
    localparam int TABLE_W = NUM_SETS * PAIR_W;

    phase_e             state_q, state_d;
    logic               fresh_q;
    logic [2:0]         flag_s;
    logic               lo_s, mid_s, tgt_s;
    logic               switching;
    logic [TABLE_W-1:0] table_q;
    logic [PAIR_W-1:0]  pair_sel;
    logic [CODE_W-1:0]  per_code, on_code;
    logic               wrap;

    rpc_flag_sync #(.N(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({cmp_tgt, cmp_mid, cmp_lo}),
        .q   (flag_s)
    );
    assign lo_s  = flag_s[0];
    assign mid_s = flag_s[1];
    assign tgt_s = flag_s[2];

    rpc_cfg_table #(.TABLE_W(TABLE_W), .DEF_TABLE(DEF_TABLE)) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_shift),
        .sdata     (cfg_data),
        .commit    (cfg_load),
        .commit_ok (!switching),
        .table_q   (table_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = entry_phase(lo_s, mid_s, tgt_s);
            ST_COARSE: begin
                if (tgt_s)      state_d = ST_DONE;
                else if (mid_s) state_d = ST_FINE;
                else if (lo_s)  state_d = ST_MEDIUM;
            end
            ST_MEDIUM: begin
                if (tgt_s)      state_d = ST_DONE;
                else if (mid_s) state_d = ST_FINE;
            end
            ST_FINE:   if (tgt_s) state_d = ST_DONE;
            ST_DONE:   if (start) state_d = entry_phase(lo_s, mid_s, tgt_s);
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fresh_q <= 1'b0;
        end else begin
            state_q <= state_d;
            fresh_q <= (state_d != state_q);
        end
    end

    // outputs: phase selects its stored pair
    always_comb begin
        switching = 1'b0;
        pair_sel  = table_q[2*PAIR_W +: PAIR_W];
        unique case (state_q)
            ST_COARSE: begin
                switching = 1'b1;
                pair_sel  = table_q[2*PAIR_W +: PAIR_W];
            end
            ST_MEDIUM: begin
                switching = 1'b1;
                pair_sel  = table_q[PAIR_W +: PAIR_W];
            end
            ST_FINE: begin
                switching = 1'b1;
                pair_sel  = table_q[0 +: PAIR_W];
            end
            default: switching = 1'b0;
        endcase
        per_code = pair_sel[PAIR_W-1:CODE_W];
        on_code  = pair_sel[CODE_W-1:0];
    end

    rpc_pulse_timer #(.CODE_W(CODE_W), .PER_UNIT(PER_UNIT), .ON_UNIT(ON_UNIT)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (switching),
        .fresh    (fresh_q),
        .per_code (per_code),
        .on_code  (on_code),
        .gate_o   (gate_out),
        .wrap_o   (wrap)
    );
endmodule

// File: rtl/ramp_pulse_chk.sv
module ramp_pulse_chk
    import ramp_pulse_pkg::*;
#(
    parameter int TABLE_W = 30
) (
    input logic               clk,
    input logic               rst_n,
    input phase_e             state_q,
    input logic               gate_out,
    input logic               tgt_s,
    input logic               wrap,
    input logic [TABLE_W-1:0] table_q
);
    logic running;
    assign running = (state_q == ST_COARSE) || (state_q == ST_MEDIUM) || (state_q == ST_FINE);

    // R6
    gate_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !gate_out);

    // R7
    phase_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> (state_q == ST_DONE) || (state_q >= $past(state_q)));

    // R4
    low_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> !gate_out);

    // R6
    target_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tgt_s) |=> (state_q == ST_DONE));

    // R9
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(table_q));
endmodule

bind ramp_pulse_ctrl ramp_pulse_chk #(.TABLE_W(TABLE_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .gate_out (gate_out),
    .tgt_s    (tgt_s),
    .wrap     (wrap),
    .table_q  (table_q)
);

// File: tb/ramp_pulse_ctrl_tb_top.sv
module ramp_pulse_ctrl_tb_top;
    localparam int PU = 2;
    localparam int OU = 1;
    localparam logic [29:0] DEF = {5'd12, 5'd10, 5'd6, 5'd4, 5'd3, 5'd2};

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, cmp_lo = 0, cmp_mid = 0, cmp_tgt = 0;
    logic cfg_shift = 0, cfg_data = 0, cfg_load = 0;
    logic gate_out;

    int checks = 0, errors = 0;
    bit mon_en = 0, done_flag = 0;

    always #10 clk = ~clk;

    ramp_pulse_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cmp_lo(cmp_lo), .cmp_mid(cmp_mid), .cmp_tgt(cmp_tgt),
        .cfg_shift(cfg_shift), .cfg_data(cfg_data), .cfg_load(cfg_load),
        .gate_out(gate_out)
    );

    // expected values from the requirements
    function automatic int exp_per(input int pc);
        int c = (pc == 0) ? 1 : pc;
        return (c * PU < 2) ? 2 : c * PU;
    endfunction
    function automatic int exp_hi(input int pc, input int oc);
        int c = (oc == 0) ? 1 : oc;
        int p = exp_per(pc);
        return (c * OU >= p) ? p - 1 : c * OU;
    endfunction
    function automatic logic [9:0] slot(input logic [29:0] t, input int ph);
        if (ph == 1)      return t[29:20];
        else if (ph == 2) return t[19:10];
        else              return t[9:0];
    endfunction
    function automatic int next_ph(input int st, input logic [2:0] f, input logic s);
        int e = f[2] ? 4 : f[1] ? 3 : f[0] ? 2 : 1;
        case (st)
            0, 4: return s ? e : st;
            1: return f[2] ? 4 : f[1] ? 3 : f[0] ? 2 : 1;
            2: return f[2] ? 4 : f[1] ? 3 : 2;
            3: return f[2] ? 4 : 3;
            default: return 0;
        endcase
    endfunction

    // cycle model
    logic [2:0] m_s1, m_s2;
    int m_state, m_cnt;
    bit m_fresh;
    logic [29:0] m_sr, m_tab;

    function automatic bit m_run(input int st);
        return st >= 1 && st <= 3;
    endfunction
    function automatic bit m_gate();
        int ce, pc, oc;
        if (!m_run(m_state)) return 0;
        ce = m_fresh ? 0 : m_cnt;
        pc = int'(slot(m_tab, m_state)[9:5]);
        oc = int'(slot(m_tab, m_state)[4:0]);
        return ce < exp_hi(pc, oc);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int nx, ce, pe;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_state <= 0; m_fresh <= 0; m_cnt <= 0;
            m_sr <= 0; m_tab <= DEF;
        end else begin
            m_s1 <= {cmp_tgt, cmp_mid, cmp_lo};
            m_s2 <= m_s1;
            nx = next_ph(m_state, m_s2, start);
            m_fresh <= (nx != m_state);
            m_state <= nx;
            if (cfg_shift) m_sr <= {m_sr[28:0], cfg_data};
            if (cfg_load && !m_run(m_state)) m_tab <= m_sr;
            if (!m_run(m_state)) m_cnt <= 0;
            else begin
                ce = m_fresh ? 0 : m_cnt;
                pe = exp_per(int'(slot(m_tab, m_state)[9:5]));
                m_cnt <= (ce == pe - 1) ? 0 : ce + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            bit e;
            e = m_gate();
            if (m_state == 0 || m_state == 4)
                check(gate_out == e, "R6 gate in idle/done", gate_out, e);
            else if (m_state == 1)
                check(gate_out == e, "R2 coarse train", gate_out, e);
            else
                check(gate_out == e, "R5 medium/fine train", gate_out, e);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic kick();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask
    task automatic load(input logic [29:0] v);
        for (int i = 29; i >= 0; i--) begin
            @(negedge clk); cfg_data = v[i]; cfg_shift = 1;
        end
        @(negedge clk); cfg_shift = 0; cfg_load = 1;
        @(negedge clk); cfg_load = 0;
    endtask
    task automatic measure(output int hi, output int per);
        int lo;
        while (gate_out) @(negedge clk);
        while (!gate_out) @(negedge clk);
        hi = 0; lo = 0;
        while (gate_out) begin hi++; @(negedge clk); end
        while (!gate_out) begin lo++; @(negedge clk); end
        per = hi + lo;
    endtask
    task automatic expect_pair(input string req, input int pc, input int oc);
        int h, p;
        measure(h, p);
        check(h == exp_hi(pc, oc), {req, " high time"}, h, exp_hi(pc, oc));
        check(p == exp_per(pc), {req, " period"}, p, exp_per(pc));
    endtask
    task automatic expect_quiet(input string req, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gate_out) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        int h, p;
        void'($urandom(32'd4711));
        cyc(3);
        // R1: reset state, gate low while held and after release
        check(gate_out == 0, "R1 gate in reset", gate_out, 0);
        @(negedge clk); rst_n = 1;
        expect_quiet("R1 gate low before start", 10);
        mon_en = 1;

        // R2 R3: coarse from default table (period 12, on 10)
        kick();
        check(gate_out == 1, "R2 gate high right after start", gate_out, 1);
        expect_pair("R3 coarse default", 12, 10);
        // R5: medium then fine
        cmp_lo = 1; cyc(6);
        expect_pair("R5 medium default", 6, 4);
        cmp_mid = 1; cyc(6);
        expect_pair("R5 fine default", 3, 2);
        // R7: falling flags and a start during the ramp
        cmp_mid = 0; cmp_lo = 0; kick(); cyc(6);
        expect_pair("R7 stays fine", 3, 2);
        // R9: load during switching ignored
        load({5'd20, 5'd3, 5'd20, 5'd3, 5'd20, 5'd3});
        expect_pair("R9 load ignored while switching", 3, 2);
        // R6: target stops switching
        cmp_tgt = 1; cyc(4);
        expect_quiet("R6 held low at target", 60);
        // R8: start with target still set stays done
        kick(); expect_quiet("R8 restart with target set", 20);
        // R8: restart into fine
        cmp_tgt = 0; cmp_lo = 1; cmp_mid = 1; cyc(4); kick();
        expect_pair("R8 re-entry to fine", 3, 2);
        cmp_tgt = 1; cyc(6);
        // R8: restart into medium
        cmp_tgt = 0; cmp_mid = 0; cyc(4); kick();
        expect_pair("R8 re-entry to medium", 6, 4);
        cmp_tgt = 1; cyc(6);

        // R4 R9: clamp table loaded in done
        load({5'd0, 5'd0, 5'd1, 5'd31, 5'd31, 5'd31});
        cmp_tgt = 0; cmp_lo = 0; cmp_mid = 0; cyc(4); kick();
        expect_pair("R4 zero codes", 0, 0);
        cmp_lo = 1; cyc(6);
        expect_pair("R4 on above period", 1, 31);
        cmp_mid = 1; cyc(6);
        expect_pair("R3 full-scale codes", 31, 31);
        cmp_tgt = 1; cyc(6);

        // random ramps against the model
        for (int r = 0; r < 30; r++) begin
            logic [29:0] t;
            int sel;
            if ($urandom % 2 == 1) begin
                t = 30'($urandom);
                load(t);
            end
            sel = $urandom % 3;
            cmp_tgt = 0; cmp_lo = (sel != 0); cmp_mid = (sel == 2);
            cyc(4); kick();
            cyc(10 + $urandom % 80);
            cmp_lo = 1;
            if ($urandom % 3 == 0) begin cyc(2); cmp_lo = 0; cyc(3); cmp_lo = 1; end
            cyc(10 + $urandom % 80);
            cmp_mid = 1;
            cyc(10 + $urandom % 60);
            if ($urandom % 3 == 0) load(30'($urandom));
            if ($urandom % 4 == 0) kick();
            cmp_tgt = 1;
            cyc(8);
            if ($urandom % 2 == 1) kick();
            cyc(4);
        end
        summary();
    end
endmodule